// File: doc/BRIEF.md
# Serial Receiver with Protected Holding Register

This block turns an asynchronous serial line into bytes. A frame has one low start bit, eight data bits (least significant first), an optional parity bit and one stop bit. The line is sampled with a single-cycle enable, `os_tick`, that pulses sixteen times per bit period. A small sampler finds the start edge, checks the start bit again at its midpoint, and then takes each later bit at the centre of its period. The finished byte goes into a one-byte holding register, along with per-byte flags for parity error, framing error and break.

When a second frame completes while the held byte is still unread, the held byte is kept intact. The overrun goes into a private pending flag. The host first collects the valid byte with a data read. Only then do the overrun flag and the break flag become visible. `rx_avail` stays high to show that the register still holds a byte, and that byte must be thrown away. After the host has read the status while it shows the overrun, one more data read clears the errors and empties the register. A single interrupt output is the OR of all receive sources. A mask input removes only the data-available source.

Top module: `uart_rx_guard`

## Requirements
- R1: After synchronous reset, `rx_avail`, `err_over`, `err_frame`, `err_par`, `brk_det` and `irq` are 0 and `rx_data` is 8'h00.
- R2: Frame format and delivery:
  - A frame is a start bit (0), then data bits sent LSB first, then an optional parity bit, then a stop bit (1). Each bit lasts 16 `os_tick` pulses, and `os_tick` may arrive at any rate.
  - When a frame completes into an empty register, its byte appears on `rx_data` with `rx_avail`=1.
  - A `rd_data` pulse on a normally held byte clears `rx_avail`.
- R3: Parity:
  - With `par_en`=1, one parity bit follows the data.
  - With `par_odd`=0 the data bits and the parity bit together must hold an even number of ones. With `par_odd`=1 they must hold an odd number.
  - A mismatch sets `err_par` for that byte. A correct parity bit leaves `err_par` at 0.
- R4: A stop bit sampled low sets `err_frame` for that byte and does not set `brk_det` if any data bit was 1.
- R5: Break:
  - A frame whose start bit, data bits, parity bit (when enabled) and stop bit all sample low is a break.
  - A break sets `brk_det` and `err_frame` and loads 8'h00.
  - The receiver then waits for the line to return high, so a line held low yields exactly one frame.
- R6: A low pulse shorter than half a bit period is rejected as a false start and produces no byte.
- R7: A frame that completes while `rx_avail`=1 does not change `rx_data`. It leaves `err_over` and `brk_det` as they were (hidden).
- R8: The first `rd_data` after a hidden overrun sets `err_over`=1 and keeps `rx_avail`=1.
- R9: When the overrun is revealed, `brk_det` is 1 exactly when one of the overrunning frames was a break.
- R10: Clearing an overrun:
  - While `err_over`=1, a `rd_data` clears `rx_avail`, `err_over`, `brk_det`, `err_frame` and `err_par` only if a `rd_stat` pulse occurred after `err_over` became 1.
  - Without that status read, the data read has no effect.
- R11: Interrupt:
  - `irq` = (`rx_avail` AND NOT `avail_irq_mask`) OR `err_over` OR `brk_det` OR `err_frame` OR `err_par`.
  - The mask suppresses only the data-available term.
- R12: `rx_avail` never rises before the received byte is present on `rx_data`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| os_tick | input | 1 | Oversampling enable, 16 pulses per bit |
| rxd | input | 1 | Serial line, idle high |
| par_en | input | 1 | 1 = frame carries a parity bit |
| par_odd | input | 1 | 1 = odd parity, 0 = even parity |
| avail_irq_mask | input | 1 | 1 = data-available does not drive `irq` |
| rd_data | input | 1 | One-cycle data read strobe |
| rd_stat | input | 1 | One-cycle status read strobe |
| rx_data | output | 8 | Holding register contents |
| rx_avail | output | 1 | Holding register holds a byte |
| err_over | output | 1 | Overrun flag (visible after the protected byte is read) |
| err_frame | output | 1 | Framing error |
| err_par | output | 1 | Parity error |
| brk_det | output | 1 | Break detected |
| irq | output | 1 | Combined receive interrupt |

## Verification
The hardest state to reach is an overrun caused by a break that is still hidden behind an unread byte. It needs a full clean frame left unread, then a whole low frame, then a rising line, all with no host access in between. The stimulus sends byte 8'h11, never reads it, and drives an all-low frame. It then checks that the held byte and the hidden flags did not move. A data read follows, and the check is that the revealed break and overrun appear. The clear sequence is run both with and without the status read in between.

// File: rtl/uart_rxg_pkg.sv
package uart_rxg_pkg;

    localparam int DATA_W = 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PAR,
        ST_STOP,
        ST_HOLD
    } rx_state_e;

    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic              ferr;
        logic              perr;
        logic              brk;
    } rx_frame_t;

    typedef struct packed {
        logic avail;
        logic ovr;
        logic brk;
        logic ferr;
        logic perr;
    } rx_flags_t;

    // Parity bit value the sender must have used
    function automatic logic parity_of(input logic [DATA_W-1:0] d, input logic odd);
        return (^d) ^ odd;
    endfunction

endpackage

// File: rtl/uart_rxg_sync.sv
module uart_rxg_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] q;

    always_ff @(posedge clk) begin
        if (rst) q <= '1;
        else     q <= STAGES'({q, din});
    end

    assign dout = q[STAGES-1];
endmodule

// File: rtl/uart_rxg_framer.sv
module uart_rxg_framer
    import uart_rxg_pkg::*;
#(
    parameter int OSR = 16
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      tick,
    input  logic      rxs,
    input  logic      par_en,
    input  logic      par_odd,
    output logic      done,
    output rx_frame_t frame
);
    localparam int CW = $clog2(OSR);
    localparam int IW = $clog2(DATA_W);
    localparam logic [CW-1:0] MID      = CW'(OSR / 2 - 1);
    localparam logic [CW-1:0] LAST     = CW'(OSR - 1);
    localparam logic [IW-1:0] IDX_LAST = IW'(DATA_W - 1);

    rx_state_e         st;
    logic [CW-1:0]     cnt;
    logic [IW-1:0]     idx;
    logic [DATA_W-1:0] sh;
    logic              pbit;

    always_ff @(posedge clk) begin
        if (rst) begin
            st    <= ST_IDLE;
            cnt   <= '0;
            idx   <= '0;
            sh    <= '0;
            pbit  <= 1'b0;
            done  <= 1'b0;
            frame <= '0;
        end else begin
            done <= 1'b0;
            if (tick) begin
                unique case (st)
                    ST_IDLE: begin
                        if (!rxs) begin
                            st  <= ST_START;
                            cnt <= '0;
                        end
                    end
                    ST_START: begin
                        if (cnt == MID) begin
                            cnt  <= '0;
                            idx  <= '0;
                            pbit <= 1'b0;
                            st   <= rxs ? ST_IDLE : ST_DATA;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    ST_DATA: begin
                        if (cnt == LAST) begin
                            cnt <= '0;
                            sh  <= {rxs, sh[DATA_W-1:1]};
                            if (idx == IDX_LAST) st <= par_en ? ST_PAR : ST_STOP;
                            else                 idx <= idx + 1'b1;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    ST_PAR: begin
                        if (cnt == LAST) begin
                            cnt  <= '0;
                            pbit <= rxs;
                            st   <= ST_STOP;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    ST_STOP: begin
                        if (cnt == LAST) begin
                            cnt        <= '0;
                            done       <= 1'b1;
                            frame.data <= sh;
                            frame.ferr <= !rxs;
                            frame.perr <= par_en && (pbit != parity_of(sh, par_odd));
                            frame.brk  <= !rxs && (sh == '0) && !(par_en && pbit);
                            st         <= rxs ? ST_IDLE : ST_HOLD;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    ST_HOLD: begin
                        if (rxs) st <= ST_IDLE;
                    end
                    default: st <= ST_IDLE;
                endcase
            end
        end
    end
endmodule

// File: rtl/uart_rxg_hold.sv
module uart_rxg_hold
    import uart_rxg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_data,
    input  logic              rd_stat,
    input  logic              done,
    input  rx_frame_t         frame,
    output logic [DATA_W-1:0] data_q,
    output rx_flags_t         flags_q
);
    logic              pend_q, pbrk_q, seen_q;
    logic              pend_d, pbrk_d, seen_d;
    rx_flags_t         flags_d;
    logic [DATA_W-1:0] data_d;

    always_comb begin
        flags_d = flags_q;
        data_d  = data_q;
        pend_d  = pend_q;
        pbrk_d  = pbrk_q;
        seen_d  = seen_q;

        if (rd_stat && flags_q.ovr) seen_d = 1'b1;

        if (rd_data) begin
            if (pend_q) begin
                // reveal the hidden overrun; byte now held is to be discarded
                flags_d.ovr = 1'b1;
                flags_d.brk = pbrk_q;
                pend_d      = 1'b0;
                pbrk_d      = 1'b0;
                seen_d      = 1'b0;
            end else if (flags_q.ovr) begin
                if (seen_q) begin
                    flags_d = '0;
                    seen_d  = 1'b0;
                end
            end else begin
                flags_d = '0;
            end
        end

        if (done) begin
            if (!flags_d.avail) begin
                data_d        = frame.data;
                flags_d.avail = 1'b1;
                flags_d.ovr   = 1'b0;
                flags_d.brk   = frame.brk;
                flags_d.ferr  = frame.ferr;
                flags_d.perr  = frame.perr;
            end else begin
                pend_d = 1'b1;
                pbrk_d = pbrk_d | frame.brk;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flags_q <= '0;
            data_q  <= '0;
            pend_q  <= 1'b0;
            pbrk_q  <= 1'b0;
            seen_q  <= 1'b0;
        end else begin
            flags_q <= flags_d;
            data_q  <= data_d;
            pend_q  <= pend_d;
            pbrk_q  <= pbrk_d;
            seen_q  <= seen_d;
        end
    end
endmodule

// File: rtl/uart_rx_guard.sv
module uart_rx_guard
    import uart_rxg_pkg::*;
#(
    parameter int OSR         = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              os_tick,
    input  logic              rxd,
    input  logic              par_en,
    input  logic              par_odd,
    input  logic              avail_irq_mask,
    input  logic              rd_data,
    input  logic              rd_stat,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_avail,
    output logic              err_over,
    output logic              err_frame,
    output logic              err_par,
    output logic              brk_det,
    output logic              irq
);
    logic      rx_sync;
    logic      frame_done;
    rx_frame_t frame;
    rx_flags_t flags;

    uart_rxg_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .din  (rxd),
        .dout (rx_sync)
    );

    uart_rxg_framer #(.OSR(OSR)) u_framer (
        .clk     (clk),
        .rst     (rst),
        .tick    (os_tick),
        .rxs     (rx_sync),
        .par_en  (par_en),
        .par_odd (par_odd),
        .done    (frame_done),
        .frame   (frame)
    );

    uart_rxg_hold u_hold (
        .clk     (clk),
        .rst     (rst),
        .rd_data (rd_data),
        .rd_stat (rd_stat),
        .done    (frame_done),
        .frame   (frame),
        .data_q  (rx_data),
        .flags_q (flags)
    );

    assign rx_avail  = flags.avail;
    assign err_over  = flags.ovr;
    assign err_frame = flags.ferr;
    assign err_par   = flags.perr;
    assign brk_det   = flags.brk;
    assign irq       = (flags.avail & ~avail_irq_mask) | flags.ovr | flags.brk
                     | flags.ferr | flags.perr;
endmodule

// File: rtl/uart_rxg_chk.sv
module uart_rxg_chk (
    input logic       clk,
    input logic       rst,
    input logic       rd_data,
    input logic       frame_done,
    input logic       avail_irq_mask,
    input logic [7:0] rx_data,
    input logic       rx_avail,
    input logic       err_over,
    input logic       err_frame,
    input logic       err_par,
    input logic       brk_det,
    input logic       irq
);
    AST_HOLD_PROTECT: assert property (@(posedge clk) disable iff (rst)
        !$stable(rx_data) |-> $past(!rx_avail || rd_data)); // R7

    AST_OVR_AFTER_READ: assert property (@(posedge clk) disable iff (rst)
        $rose(err_over) |-> $past(rd_data)); // R8

    AST_OVR_KEEPS_AVAIL: assert property (@(posedge clk) disable iff (rst)
        err_over |-> rx_avail); // R8

    AST_OVR_CLEAR_BY_READ: assert property (@(posedge clk) disable iff (rst)
        $fell(err_over) |-> $past(rd_data)); // R10

    AST_BRK_WITH_ERR: assert property (@(posedge clk) disable iff (rst)
        brk_det |-> (err_frame || err_over)); // R5

    AST_MASK_ONLY_AVAIL: assert property (@(posedge clk) disable iff (rst)
        (avail_irq_mask && !err_over && !brk_det && !err_frame && !err_par) |-> !irq); // R11

    AST_ERR_RAISES_IRQ: assert property (@(posedge clk) disable iff (rst)
        (err_over || brk_det || err_frame || err_par) |-> irq); // R11

    AST_AVAIL_AFTER_LOAD: assert property (@(posedge clk) disable iff (rst)
        $rose(rx_avail) |-> $past(frame_done)); // R12
endmodule

bind uart_rx_guard uart_rxg_chk u_chk (
    .clk            (clk),
    .rst            (rst),
    .rd_data        (rd_data),
    .frame_done     (frame_done),
    .avail_irq_mask (avail_irq_mask),
    .rx_data        (rx_data),
    .rx_avail       (rx_avail),
    .err_over       (err_over),
    .err_frame      (err_frame),
    .err_par        (err_par),
    .brk_det        (brk_det),
    .irq            (irq)
);

// File: tb/uart_rx_guard_bench.sv
module uart_rx_guard_bench;
    localparam int OSR = 16;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic rst = 1'b1, os_tick = 1'b0, rxd = 1'b1, par_en = 1'b0, par_odd = 1'b0;
    logic mask = 1'b0, rd_data = 1'b0, rd_stat = 1'b0;
    logic [7:0] rx_data;
    logic rx_avail, err_over, err_frame, err_par, brk_det, irq;

    int n_chk = 0, n_bad = 0;
    int div = 1, tcnt = 0;
    logic [7:0] exp_byte = 8'h00;
    logic prev_av = 1'b0;

    uart_rx_guard u_uart_rx_guard (
        .clk (clk), .rst (rst), .os_tick (os_tick), .rxd (rxd),
        .par_en (par_en), .par_odd (par_odd), .avail_irq_mask (mask),
        .rd_data (rd_data), .rd_stat (rd_stat), .rx_data (rx_data),
        .rx_avail (rx_avail), .err_over (err_over), .err_frame (err_frame),
        .err_par (err_par), .brk_det (brk_det), .irq (irq)
    );

    always @(negedge clk) begin
        if (tcnt >= div - 1) begin tcnt = 0; os_tick = 1'b1; end
        else begin tcnt = tcnt + 1; os_tick = 1'b0; end
    end

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // R12: whenever rx_avail rises the expected byte is already on rx_data
    always @(negedge clk) begin
        if (!rst && rx_avail && !prev_av) chk("R12 data present at avail rise", rx_data, exp_byte);
        prev_av = rx_avail;
    end

    task automatic wait_ticks(input int n);
        int k = 0;
        while (k < n) begin
            @(posedge clk);
            if (os_tick) k++;
        end
    endtask

    task automatic drive_bit(input logic b);
        @(negedge clk) rxd = b;
        wait_ticks(OSR);
    endtask

    task automatic line_high(input int n);
        @(negedge clk) rxd = 1'b1;
        wait_ticks(n);
    endtask

    task automatic send_frame(input logic [7:0] d, input logic with_par,
                              input logic pbit, input logic stopb);
        exp_byte = d;
        drive_bit(1'b0);
        for (int i = 0; i < 8; i++) drive_bit(d[i]);
        if (with_par) drive_bit(pbit);
        drive_bit(stopb);
        if (stopb) wait_ticks(8);
    endtask

    task automatic read_data();
        @(negedge clk) rd_data = 1'b1;
        @(negedge clk) rd_data = 1'b0;
    endtask

    task automatic read_stat();
        @(negedge clk) rd_stat = 1'b1;
        @(negedge clk) rd_stat = 1'b0;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 rx_avail", rx_avail, 0);
        chk("R1 err_over", err_over, 0);
        chk("R1 err_frame", err_frame, 0);
        chk("R1 err_par", err_par, 0);
        chk("R1 brk_det", brk_det, 0);
        chk("R1 irq", irq, 0);
        chk("R1 rx_data", rx_data, 0);

        // R2: every byte value, no parity
        for (int b = 0; b < 256; b++) begin
            send_frame(8'(b), 1'b0, 1'b0, 1'b1);
            chk("R2 data", rx_data, b);
            chk("R2 avail", rx_avail, 1);
            chk("R4 no ferr", err_frame, 0);
            chk("R3 no perr", err_par, 0);
            chk("R11 irq on avail", irq, 1);
            read_data();
            chk("R2 avail cleared", rx_avail, 0);
        end

        // R3: parity, both senses, good and bad
        par_en = 1'b1;
        for (int i = 0; i < 64; i++) begin
            logic [7:0] d;
            logic odd, bad;
            d = 8'((i * 37 + 5) & 255);
            odd = i[0];
            bad = i[1];
            par_odd = odd;
            send_frame(d, 1'b1, (^d) ^ odd ^ bad, 1'b1);
            chk("R3 data", rx_data, d);
            chk("R3 perr", err_par, bad);
            chk("R11 irq", irq, 1);
            read_data();
            chk("R3 perr cleared", err_par, 0);
        end
        par_en = 1'b0; par_odd = 1'b0;

        // R2: slower oversampling tick
        div = 3;
        for (int i = 0; i < 8; i++) begin
            send_frame(8'(8'h17 * (i + 1)), 1'b0, 1'b0, 1'b1);
            chk("R2 slow tick data", rx_data, 8'(8'h17 * (i + 1)));
            read_data();
        end
        div = 1;

        // R4: framing error, nonzero data
        send_frame(8'h5A, 1'b0, 1'b0, 1'b0);
        line_high(24);
        chk("R4 ferr", err_frame, 1);
        chk("R4 no brk", brk_det, 0);
        chk("R4 data", rx_data, 8'h5A);
        read_data();
        chk("R4 ferr cleared", err_frame, 0);

        // R5: break held low well past one frame
        send_frame(8'h00, 1'b0, 1'b0, 1'b0);
        wait_ticks(48);
        line_high(24);
        chk("R5 brk", brk_det, 1);
        chk("R5 ferr", err_frame, 1);
        chk("R5 data", rx_data, 0);
        chk("R5 avail", rx_avail, 1);
        read_data();
        line_high(40);
        chk("R5 single frame", rx_avail, 0);

        // R6: short low glitch
        @(negedge clk) rxd = 1'b0;
        wait_ticks(5);
        line_high(40);
        chk("R6 glitch ignored", rx_avail, 0);
        send_frame(8'h81, 1'b0, 1'b0, 1'b1);
        chk("R6 recovers", rx_data, 8'h81);
        read_data();

        // R7/R8/R10: plain overrun
        send_frame(8'hA5, 1'b0, 1'b0, 1'b1);
        send_frame(8'h3C, 1'b0, 1'b0, 1'b1);
        chk("R7 held data", rx_data, 8'hA5);
        chk("R7 ovr hidden", err_over, 0);
        chk("R7 brk hidden", brk_det, 0);
        read_data();
        chk("R8 ovr shown", err_over, 1);
        chk("R8 avail kept", rx_avail, 1);
        chk("R9 no brk", brk_det, 0);
        read_data();
        chk("R10 no status read keeps ovr", err_over, 1);
        chk("R10 no status read keeps avail", rx_avail, 1);
        read_stat();
        read_data();
        chk("R10 ovr cleared", err_over, 0);
        chk("R10 avail cleared", rx_avail, 0);
        chk("R11 irq idle", irq, 0);

        // R9: overrun caused by a break
        send_frame(8'h11, 1'b0, 1'b0, 1'b1);
        send_frame(8'h00, 1'b0, 1'b0, 1'b0);
        line_high(24);
        chk("R7 held through break", rx_data, 8'h11);
        chk("R7 brk hidden", brk_det, 0);
        chk("R7 ovr hidden", err_over, 0);
        read_data();
        chk("R9 brk shown", brk_det, 1);
        chk("R8 ovr shown", err_over, 1);
        read_stat();
        read_data();
        chk("R10 brk cleared", brk_det, 0);
        chk("R10 ovr cleared", err_over, 0);

        // R11: mask blocks only the data-available source
        mask = 1'b1;
        send_frame(8'h42, 1'b0, 1'b0, 1'b1);
        chk("R11 masked avail", rx_avail, 1);
        chk("R11 masked irq", irq, 0);
        read_data();
        send_frame(8'h42, 1'b0, 1'b0, 1'b0);
        line_high(24);
        chk("R11 ferr irq under mask", irq, 1);
        read_data();
        mask = 1'b0;

        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule